// File: doc/BRIEF.md
# Variable-Segment Compressed Cache Set Controller

This block keeps the tag and space accounting for the sets of a compressed cache. Each set carries four tag entries but data room for only two full-size lines. Line data is measured in 8-byte segments, 16 per set. A line stored in compressed form takes between 1 and 8 segments, and an uncompressed line always takes 8. A tag entry can remain valid after its data has been thrown out. Lookups report that case apart from a full hit, so an outer policy can tell a miss that compression would have avoided from one it could not have avoided.

Each request names a set, an address tag and an operation: lookup, fill, evict, or probe. A probe is a lookup that leaves the replacement order alone. The block answers one cycle later with the following fields:
- whether the tag was present, and whether its data was resident;
- its recency position, plus its stored compression status and permission bits;
- for a fill, the tag that had to be evicted entirely, if any, and how many other lines lost their data;
- the number of segments in use in the set after the operation.

The segment payload bytes and the compression algorithm lie outside this block.

Top module: `csc_set_ctrl`

## Requirements
- R1: A synchronous reset clears every entry of every set and the response outputs. A lookup after reset misses, with position 0 and 0 segments in use.
- R2: Every request accepted on a clock edge gives exactly one response with `rsp_valid` high after that edge. With no request, `rsp_valid` is low.
- R3: A lookup or probe that matches a valid tag reports `rsp_hit`=1 and its position, where 1 is the most recent and 4 the least recent. `rsp_data` shows whether its data is resident. A non-matching request reports hit 0, data 0 and position 0. Data never shows without hit.
- R4: A lookup (op 2'b00) that matches moves the tag to position 1. Tags that were above it each move down one place. A probe (op 2'b11) never changes the order.
- R5: A fill (op 2'b01) of an absent tag puts it at position 1 with its data resident. If all four entries were valid, the least recent tag is dropped entirely and reported on `rsp_victim_vld`/`rsp_victim_tag`. Otherwise nothing is reported there.
- R6: A line's segment cost is 8 when `req_comp`=0. When `req_comp`=1 the cost is `req_size`, except that 0 or anything above 8 costs 8.
- R7: After a fill, resident data is stripped from the least recent tags first until the resident costs total at most 16. A stripped tag stays valid and later looks up as hit with no data. `rsp_drop_cnt` gives the number stripped.
- R8: A fill whose tag is valid but has no data reuses that entry: no victim, no other tag lost, and the entry moves to position 1.
- R9: A fill whose tag already holds data replaces its cost, compression status and permission bits. Its old cost is not counted.
- R10: An evict (op 2'b10) of a present tag removes it, and the less recent tags each move up one place. An evict of an absent tag changes nothing. `rsp_hit` tells which case occurred.
- R11: Sets are independent; a request changes only the set it names.
- R12: On a match, `rsp_comp` and `rsp_perm` return the compression status and permission bits stored with the tag before the request. On no match both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 lookup, 01 fill, 10 evict, 11 probe |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Address tag |
| req_comp | input | 1 | Fill data is compressed |
| req_size | input | SZ_W | Compressed size in segments |
| req_perm | input | PERM_W | Permission bits stored on fill |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Tag was present |
| rsp_data | output | 1 | Tag's data was resident |
| rsp_pos | output | POS_W | Recency position of matched tag, 0 if none |
| rsp_comp | output | 1 | Stored compression status of matched tag |
| rsp_perm | output | PERM_W | Stored permission bits of matched tag |
| rsp_victim_vld | output | 1 | Fill dropped a whole tag |
| rsp_victim_tag | output | TAG_W | Tag that was dropped |
| rsp_drop_cnt | output | POS_W | Lines whose data was stripped |
| rsp_seg_used | output | USE_W | Resident segments in the set after the request |

## Verification
A fill can evict the least recent tag entirely and, in the same cycle, strip the data of other surviving tags to meet the segment budget. The bench sets this up by filling three or four tags whose costs add up close to 16, then filling a new uncompressed tag into the full set. It judges the outcome by the victim tag, the strip count and the segment total in the fill response. Follow-up lookups must show the victim missing, the stripped tags present without data, and the new tag at position 1. A long pseudo-random stream over a small tag pool then repeats this and similar collisions against the bench's own model.

// File: rtl/csc_pkg.sv
package csc_pkg;

   typedef enum logic [1:0] {
      OP_LOOK  = 2'b00,
      OP_FILL  = 2'b01,
      OP_DROP  = 2'b10,
      OP_PROBE = 2'b11
   } csc_op_e;

   // Segment cost of a line (R6): uncompressed or out-of-range sizes cost a full line
   function automatic int unsigned seg_cost(input logic comp,
                                            input int unsigned size,
                                            input int unsigned max_seg);
      if (!comp || size == 0 || size > max_seg) return max_seg;
      return size;
   endfunction

endpackage

// File: rtl/csc_match.sv
module csc_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            vld_i,
   input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
   input  logic [TAG_W-1:0]           key_i,
   output logic                       found_o,
   output logic [IDX_W-1:0]           idx_o
);

   logic [WAYS-1:0] eq;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign eq[g] = vld_i[g] && (tag_i[g] == key_i);
   end

   always_comb begin
      found_o = |eq;
      idx_o   = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (eq[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/csc_reorder.sv
module csc_reorder
   import csc_pkg::*;
#(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 20,
   parameter int SZ_W   = 4,
   parameter int PERM_W = 2,
   localparam int IDX_W = $clog2(WAYS),
   localparam int ENT_W = 3 + PERM_W + SZ_W + TAG_W
) (
   input  csc_op_e                    op_i,
   input  logic                       found_i,
   input  logic [IDX_W-1:0]           idx_i,
   input  logic [WAYS-1:0][ENT_W-1:0] cur_i,
   input  logic [ENT_W-1:0]           new_i,
   output logic [WAYS-1:0][ENT_W-1:0] nxt_o,
   output logic                       vic_vld_o,
   output logic [TAG_W-1:0]           vic_tag_o
);

   typedef struct packed {
      logic              v;
      logic              d;
      logic              c;
      logic [PERM_W-1:0] p;
      logic [SZ_W-1:0]   s;
      logic [TAG_W-1:0]  t;
   } ent_t;

   ent_t [WAYS-1:0] cur, nxt;
   ent_t            ne;
   int              lim;

   assign cur   = cur_i;
   assign ne    = new_i;
   assign nxt_o = nxt;

   always_comb begin
      nxt       = cur;
      vic_vld_o = 1'b0;
      vic_tag_o = '0;
      lim       = found_i ? int'(idx_i) : WAYS - 1;
      unique case (op_i)
         OP_LOOK: begin
            // R4: matched entry to the top, entries above it slide down
            if (found_i) begin
               for (int i = 1; i < WAYS; i++)
                  if (i <= int'(idx_i)) nxt[i] = cur[i-1];
               nxt[0] = cur[idx_i];
            end
         end
         OP_FILL: begin
            // R5/R8/R9: new entry on top; matched entry reused, else LRU falls off
            for (int i = 1; i < WAYS; i++)
               if (i <= lim) nxt[i] = cur[i-1];
            nxt[0] = ne;
            if (!found_i && cur[WAYS-1].v) begin
               vic_vld_o = 1'b1;
               vic_tag_o = cur[WAYS-1].t;
            end
         end
         OP_DROP: begin
            // R10: remove matched entry, less recent entries move up
            if (found_i) begin
               for (int i = 0; i < WAYS - 1; i++)
                  if (i >= int'(idx_i)) nxt[i] = cur[i+1];
               nxt[WAYS-1] = '0;
            end
         end
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/csc_budget.sv
module csc_budget #(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 20,
   parameter int SZ_W   = 4,
   parameter int PERM_W = 2,
   parameter int BUDGET = 16,
   parameter int POS_W  = 3,
   parameter int USE_W  = 6,
   localparam int ENT_W = 3 + PERM_W + SZ_W + TAG_W
) (
   input  logic [WAYS-1:0][ENT_W-1:0] ent_i,
   output logic [WAYS-1:0][ENT_W-1:0] ent_o,
   output logic [POS_W-1:0]           drop_o,
   output logic [USE_W-1:0]           used_o
);

   typedef struct packed {
      logic              v;
      logic              d;
      logic              c;
      logic [PERM_W-1:0] p;
      logic [SZ_W-1:0]   s;
      logic [TAG_W-1:0]  t;
   } ent_t;

   ent_t [WAYS-1:0] li, lo;
   int              acc;
   int              drops;
   logic            full;

   assign li    = ent_i;
   assign ent_o = lo;

   // R7: keep resident data from the top of the stack while it fits;
   // from the first line that does not fit downwards, strip data
   always_comb begin
      lo    = li;
      acc   = 0;
      drops = 0;
      full  = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (li[i].v && li[i].d) begin
            if (!full && (acc + int'(li[i].s) <= BUDGET)) begin
               acc = acc + int'(li[i].s);
            end else begin
               full     = 1'b1;
               lo[i].d  = 1'b0;
               drops    = drops + 1;
            end
         end
      end
      drop_o = POS_W'(drops);
      used_o = USE_W'(acc);
   end

endmodule

// File: rtl/csc_set_ctrl.sv
module csc_set_ctrl
   import csc_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int WAYS     = 4,
   parameter int TAG_W    = 20,
   parameter int PERM_W   = 2,
   parameter int MAX_SEG  = 8,
   parameter int BUDGET   = 16,
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int IDX_W   = $clog2(WAYS),
   localparam int SZ_W    = $clog2(MAX_SEG + 1),
   localparam int POS_W   = $clog2(WAYS + 1),
   localparam int USE_W   = $clog2(WAYS * MAX_SEG + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [SET_W-1:0]  req_set,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              req_comp,
   input  logic [SZ_W-1:0]   req_size,
   input  logic [PERM_W-1:0] req_perm,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_data,
   output logic [POS_W-1:0]  rsp_pos,
   output logic              rsp_comp,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              rsp_victim_vld,
   output logic [TAG_W-1:0]  rsp_victim_tag,
   output logic [POS_W-1:0]  rsp_drop_cnt,
   output logic [USE_W-1:0]  rsp_seg_used
);

   // Elaboration-time parameter checks
   if (NUM_SETS < 2) begin : g_bad_sets
      $error("csc_set_ctrl: NUM_SETS must be at least 2");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("csc_set_ctrl: WAYS must be at least 2");
   end
   if (BUDGET < MAX_SEG) begin : g_bad_budget
      $error("csc_set_ctrl: BUDGET must hold one full line");
   end

   typedef struct packed {
      logic              v;
      logic              d;
      logic              c;
      logic [PERM_W-1:0] p;
      logic [SZ_W-1:0]   s;
      logic [TAG_W-1:0]  t;
   } ent_t;

   ent_t [WAYS-1:0] mem [NUM_SETS];
   ent_t [WAYS-1:0] cur, shuf, fin;
   ent_t            new_ent;

   logic [WAYS-1:0]            cur_v;
   logic [WAYS-1:0][TAG_W-1:0] cur_t;
   logic                       found;
   logic [IDX_W-1:0]           hit_idx;
   logic                       vic_vld;
   logic [TAG_W-1:0]           vic_tag;
   logic [POS_W-1:0]           drop_cnt;
   logic [USE_W-1:0]           used;

   assign cur = mem[req_set];

   for (genvar g = 0; g < WAYS; g++) begin : g_split
      assign cur_v[g] = cur[g].v;
      assign cur_t[g] = cur[g].t;
   end

   always_comb begin
      new_ent   = '0;
      new_ent.v = 1'b1;
      new_ent.d = 1'b1;
      new_ent.c = req_comp;
      new_ent.p = req_perm;
      new_ent.s = SZ_W'(seg_cost(req_comp, int'(req_size), MAX_SEG));   // R6
      new_ent.t = req_tag;
   end

   csc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .vld_i   (cur_v),
      .tag_i   (cur_t),
      .key_i   (req_tag),
      .found_o (found),
      .idx_o   (hit_idx)
   );

   csc_reorder #(.WAYS(WAYS), .TAG_W(TAG_W), .SZ_W(SZ_W), .PERM_W(PERM_W)) u_reorder (
      .op_i      (csc_op_e'(req_op)),
      .found_i   (found),
      .idx_i     (hit_idx),
      .cur_i     (cur),
      .new_i     (new_ent),
      .nxt_o     (shuf),
      .vic_vld_o (vic_vld),
      .vic_tag_o (vic_tag)
   );

   csc_budget #(
      .WAYS(WAYS), .TAG_W(TAG_W), .SZ_W(SZ_W), .PERM_W(PERM_W),
      .BUDGET(BUDGET), .POS_W(POS_W), .USE_W(USE_W)
   ) u_budget (
      .ent_i  (shuf),
      .ent_o  (fin),
      .drop_o (drop_cnt),
      .used_o (used)
   );

   // R1: synchronous clear; R2: one-cycle registered response; R11: only req_set written
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_SETS; s++) mem[s] <= '0;
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_data       <= 1'b0;
         rsp_pos        <= '0;
         rsp_comp       <= 1'b0;
         rsp_perm       <= '0;
         rsp_victim_vld <= 1'b0;
         rsp_victim_tag <= '0;
         rsp_drop_cnt   <= '0;
         rsp_seg_used   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) mem[req_set] <= fin;
         rsp_hit        <= found;
         rsp_data       <= found && cur[hit_idx].d;
         rsp_pos        <= found ? POS_W'(hit_idx) + POS_W'(1) : '0;
         rsp_comp       <= found && cur[hit_idx].c;
         rsp_perm       <= found ? cur[hit_idx].p : '0;
         rsp_victim_vld <= vic_vld;
         rsp_victim_tag <= vic_tag;
         rsp_drop_cnt   <= drop_cnt;
         rsp_seg_used   <= used;
      end
   end

endmodule

// File: rtl/csc_set_ctrl_chk.sv
module csc_set_ctrl_chk #(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 20,
   parameter int PERM_W = 2,
   parameter int BUDGET = 16,
   parameter int POS_W  = 3,
   parameter int USE_W  = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_data,
   input logic [POS_W-1:0]  rsp_pos,
   input logic              rsp_victim_vld,
   input logic [USE_W-1:0]  rsp_seg_used
);

   p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rsp_valid);

   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
      rsp_valid == $past(req_valid && !rst));

   p_data_needs_tag_r3: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_data) |-> rsp_hit);

   p_pos_in_range_r3: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_hit) |-> (rsp_pos >= POS_W'(1) && rsp_pos <= POS_W'(WAYS)));

   p_victim_on_new_fill_r5: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_victim_vld) |-> ($past(req_op) == 2'b01 && !rsp_hit));

   p_budget_kept_r7: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> (int'(rsp_seg_used) <= BUDGET));

endmodule

bind csc_set_ctrl csc_set_ctrl_chk #(
   .WAYS(WAYS), .TAG_W(TAG_W), .PERM_W(PERM_W),
   .BUDGET(BUDGET), .POS_W(POS_W), .USE_W(USE_W)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .req_valid      (req_valid),
   .req_op         (req_op),
   .rsp_valid      (rsp_valid),
   .rsp_hit        (rsp_hit),
   .rsp_data       (rsp_data),
   .rsp_pos        (rsp_pos),
   .rsp_victim_vld (rsp_victim_vld),
   .rsp_seg_used   (rsp_seg_used)
);

// File: tb/csc_set_ctrl_test.sv
module csc_set_ctrl_test;

   localparam int NS = 16;
   localparam int NW = 4;
   localparam logic [1:0] LOOK = 2'b00, FILL = 2'b01, DROP = 2'b10, PROBE = 2'b11;

   typedef struct packed {
      logic        hit;
      logic        data;
      logic [2:0]  pos;
      logic        comp;
      logic [1:0]  perm;
      logic        vv;
      logic [19:0] vtag;
      logic [2:0]  dcnt;
      logic [5:0]  used;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [3:0]  req_set = '0;
   logic [19:0] req_tag = '0;
   logic        req_comp = 1'b0;
   logic [3:0]  req_size = '0;
   logic [1:0]  req_perm = '0;
   logic        rsp_valid, rsp_hit, rsp_data, rsp_comp, rsp_victim_vld;
   logic [2:0]  rsp_pos, rsp_drop_cnt;
   logic [1:0]  rsp_perm;
   logic [19:0] rsp_victim_tag;
   logic [5:0]  rsp_seg_used;

   always #2.5 clk = ~clk;

   csc_set_ctrl uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
      .req_set(req_set), .req_tag(req_tag), .req_comp(req_comp),
      .req_size(req_size), .req_perm(req_perm), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_pos(rsp_pos),
      .rsp_comp(rsp_comp), .rsp_perm(rsp_perm), .rsp_victim_vld(rsp_victim_vld),
      .rsp_victim_tag(rsp_victim_tag), .rsp_drop_cnt(rsp_drop_cnt),
      .rsp_seg_used(rsp_seg_used)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 0;
   exp_t  exp_q[$];
   string tag_q[$];

   // Bench model of every set, index 0 = most recent
   bit          mv [NS][NW];
   bit          md [NS][NW];
   bit          mc [NS][NW];
   logic [19:0] mt [NS][NW];
   int          ms [NS][NW];
   logic [1:0]  mp [NS][NW];

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [63:0] got, input logic [63:0] want);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, got, want);
      end
   endtask

   task automatic send(input logic [1:0] op, input int set, input logic [19:0] tag,
                       input logic comp, input int size, input logic [1:0] perm,
                       input string rq);
      exp_t e;
      int   m, n, cost, acc, drops;
      bit   stop;
      int   src [NW];
      bit          nv [NW], nd [NW], nc [NW];
      logic [19:0] nt [NW];
      int          ns [NW];
      logic [1:0]  np [NW];
      @(negedge clk);
      e = '0;
      m = -1;
      for (int w = NW - 1; w >= 0; w--) if (mv[set][w] && mt[set][w] == tag) m = w;
      if (m >= 0) begin
         e.hit = 1'b1; e.data = md[set][m]; e.pos = 3'(m + 1);
         e.comp = mc[set][m]; e.perm = mp[set][m];
      end
      n = 0;
      if (op == FILL) begin
         cost = (!comp || size == 0 || size > 8) ? 8 : size;
         src[n] = -1; n++;
         for (int w = 0; w < NW; w++) begin
            if (mv[set][w] && w != m) begin
               if (n < NW) begin src[n] = w; n++; end
               else begin e.vv = 1'b1; e.vtag = mt[set][w]; end
            end
         end
      end else begin
         if (op == LOOK && m >= 0) begin src[n] = m; n++; end
         for (int w = 0; w < NW; w++)
            if (mv[set][w] && !(w == m && (op == LOOK || op == DROP))) begin
               src[n] = w; n++;
            end
      end
      for (int i = 0; i < NW; i++) begin
         nv[i] = 0; nd[i] = 0; nc[i] = 0; nt[i] = '0; ns[i] = 0; np[i] = '0;
         if (i < n) begin
            if (src[i] < 0) begin
               nv[i] = 1; nd[i] = 1; nc[i] = comp; nt[i] = tag; ns[i] = cost; np[i] = perm;
            end else begin
               nv[i] = 1; nd[i] = md[set][src[i]]; nc[i] = mc[set][src[i]];
               nt[i] = mt[set][src[i]]; ns[i] = ms[set][src[i]]; np[i] = mp[set][src[i]];
            end
         end
      end
      acc = 0; drops = 0; stop = 0;
      for (int i = 0; i < NW; i++) begin
         if (nv[i] && nd[i]) begin
            if (!stop && acc + ns[i] <= 16) acc += ns[i];
            else begin stop = 1; nd[i] = 0; drops++; end
         end
      end
      for (int i = 0; i < NW; i++) begin
         mv[set][i] = nv[i]; md[set][i] = nd[i]; mc[set][i] = nc[i];
         mt[set][i] = nt[i]; ms[set][i] = ns[i]; mp[set][i] = np[i];
      end
      e.dcnt = 3'(drops);
      e.used = 6'(acc);
      exp_q.push_back(e);
      tag_q.push_back(rq);
      req_valid = 1'b1; req_op = op; req_set = 4'(set); req_tag = tag;
      req_comp = comp; req_size = 4'(size); req_perm = perm;
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // Monitor: pops the oldest expected response when the design answers
   always @(negedge clk) begin
      if (!rst && rsp_valid) begin
         exp_t  g;
         exp_t  w;
         string rq;
         g = {rsp_hit, rsp_data, rsp_pos, rsp_comp, rsp_perm, rsp_victim_vld,
              rsp_victim_tag, rsp_drop_cnt, rsp_seg_used};
         if (exp_q.size() == 0) begin
            check(0, "R2", "unexpected response", 64'(g), 64'(0));
         end else begin
            w  = exp_q.pop_front();
            rq = tag_q.pop_front();
            check(g == w, rq, "response", 64'(g), 64'(w));
         end
      end
   end

   initial begin
      logic [31:0] lf;
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            mv[s][w] = 0; md[s][w] = 0; mc[s][w] = 0; mt[s][w] = '0; ms[s][w] = 0; mp[s][w] = '0;
         end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: outputs cleared by reset, before any request
      check(rsp_valid == 0 && rsp_seg_used == 0 && rsp_hit == 0, "R1", "reset outputs",
            64'({rsp_valid, rsp_hit, rsp_seg_used}), 64'(0));
      send(LOOK, 0, 20'hA0001, 0, 0, 2'd0, "R1");
      send(LOOK, 15, 20'hA0002, 0, 0, 2'd0, "R1");
      // R5/R6: uncompressed fill costs 8
      send(FILL, 0, 20'h0000A, 0, 3, 2'd1, "R6");
      send(LOOK, 0, 20'h0000A, 0, 0, 2'd0, "R3");
      send(FILL, 0, 20'h0000B, 1, 2, 2'd2, "R5");
      send(FILL, 0, 20'h0000C, 1, 6, 2'd3, "R5");
      // R7: budget overflow strips LRU data, tag kept
      send(FILL, 0, 20'h0000D, 1, 4, 2'd1, "R7");
      send(LOOK, 0, 20'h0000A, 0, 0, 2'd0, "R7");
      send(LOOK, 0, 20'h0000B, 0, 0, 2'd0, "R4");
      send(PROBE, 0, 20'h0000C, 0, 0, 2'd0, "R4");
      send(PROBE, 0, 20'h0000C, 0, 0, 2'd0, "R4");
      // R8: refill of a tag without data reuses its entry
      send(FILL, 0, 20'h0000A, 1, 3, 2'd2, "R8");
      send(PROBE, 0, 20'h0000C, 0, 0, 2'd0, "R8");
      // R5+R7 in one fill: whole-tag victim and stripped data together
      send(FILL, 0, 20'h0000E, 0, 0, 2'd0, "R5");
      send(LOOK, 0, 20'h0000C, 0, 0, 2'd0, "R5");
      send(LOOK, 0, 20'h0000D, 0, 0, 2'd0, "R7");
      // R6: compressed size 0 and 9 both cost 8
      send(FILL, 1, 20'h00100, 1, 0, 2'd0, "R6");
      send(FILL, 1, 20'h00101, 1, 9, 2'd0, "R6");
      send(FILL, 1, 20'h00102, 1, 1, 2'd0, "R6");
      // R9: refill of a resident tag replaces its size and status
      send(FILL, 1, 20'h00102, 1, 5, 2'd3, "R9");
      send(FILL, 1, 20'h00102, 0, 5, 2'd1, "R9");
      send(PROBE, 1, 20'h00102, 0, 0, 2'd0, "R12");
      // R10: evict present then absent
      send(DROP, 0, 20'h0000B, 0, 0, 2'd0, "R10");
      send(LOOK, 0, 20'h0000B, 0, 0, 2'd0, "R10");
      send(DROP, 0, 20'h0000B, 0, 0, 2'd0, "R10");
      send(PROBE, 0, 20'h0000A, 0, 0, 2'd0, "R10");
      // R11: set 5 activity leaves set 0 alone
      send(FILL, 5, 20'h0000A, 1, 7, 2'd2, "R11");
      send(PROBE, 0, 20'h0000A, 0, 0, 2'd0, "R11");
      send(PROBE, 5, 20'h0000A, 0, 0, 2'd0, "R12");
      idle(2);
      // R2: no request, no response
      check(rsp_valid == 0, "R2", "idle response", 64'(rsp_valid), 64'(0));
      // Mixed pseudo-random stream over a small tag pool
      lf = 32'h1234_5678;
      for (int k = 0; k < 1500; k++) begin
         int sel, sz, st;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         sel = int'(lf[2:0]);
         sz  = int'(lf[7:4]) % 10;
         st  = (lf[9:8] == 2'd0) ? 3 : (lf[9:8] == 2'd1) ? 15 : 0;
         send((sel < 3) ? FILL : (sel < 5) ? LOOK : (sel == 5) ? DROP : PROBE,
              st, 20'(lf[14:12]), lf[15], sz, lf[17:16], "R7");
      end
      idle(3);
      check(exp_q.size() == 0, "R2", "responses missing", 64'(exp_q.size()), 64'(0));
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL R2 watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule